// File: doc/BRIEF.md
# Shadowed Configuration Register File with Deferred Nonvolatile Commit

This block holds the configuration of a programmable oscillator behind a byte-addressed serial slave. A simple port with address, write data, write strobe and read strobe replaces the serial protocol. Each configurable value has two copies. The working copy drives the outputs. The backing copy models nonvolatile storage and survives a power cycle.

A write-control bit in the device-address register chooses how writes reach the backing copy. In write-through mode every register write also commits to the backing copy. In write-back mode writes change only the working copy until a data-less store command copies everything across. The device-address register itself always commits at once, whichever mode is set.

Each commit holds a busy flag for a parameterised number of cycles. Commit requests that arrive while the flag is high are merged into a pending mask and are not lost. A reload pulse, which models power-up, copies the backing values back into the working registers.

Top module: `cfg_shadow_regs`

## Requirements
- R1: After reset the reads return these values:
  - 02h → 60h and 03h → 00h
  - 08h → 7Dh and 09h → 00h
  - 0Dh → F0h and 0Eh → F2h
  - 37h → the factory offset (default 12h)
  - `nv_busy` is 0.
- R2: The unused bits of the registers read as fixed values:
  - The prescaler word (02h high byte, 03h bits 7:6) and the DAC word (08h high byte, 09h bits 7:6) are left-justified 10-bit values, and the six low bits of 03h and 09h read as 0.
  - Bits 7:5 of 0Eh read as 1.
  - Bits 7:4 of 0Dh read as 1.
- R3: Register 37h holds the 5-bit factory offset in bits 4:0 with zeros above. Writes to 37h have no effect.
- R4: Writes to undefined addresses change no register, and reads of undefined addresses return 00h.
- R5: With the write-control bit (0Dh bit 3) at 0, a register write is committed to the backing copy and survives a reload.
- R6: With the write-control bit at 1, a write to 02h, 03h, 08h, 09h or 0Eh changes only the working copy, and a reload restores the old value.
- R7: A write of any data to 3Fh commits all working registers to the backing copy.
- R8: A write to 0Dh commits to the backing copy in either mode, and 0Dh bits 2:0 drive `dev_addr`.
- R9: Each commit holds `nv_busy` high for exactly COMMIT_CYCLES cycles, beginning at the clock edge that accepts the write.
- R10: A commit requested while busy is queued. It starts one cycle after `nv_busy` falls, and its data reaches the backing copy.
- R11: `rdata` shows the addressed register one cycle after `rd_en` and holds its value while `rd_en` is low.
- R12: A `boot_reload` pulse loads every working register from the backing copy, and the outputs `presc_word`, `dac_word` and `offset_sel` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to factory values, both copies |
| boot_reload | input | 1 | Power-up reload of working registers from backing copy |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| nv_busy | output | 1 | Backing-store commit in progress |
| presc_word | output | 10 | Working prescaler/jitter word |
| dac_word | output | 10 | Working DAC word |
| offset_sel | output | 5 | Working offset range |
| dev_addr | output | 3 | Working slave address bits |

## Verification
The bench sets write-back mode and writes a value. It then reloads and checks that the old value comes back. A design that always wrote through would return the new value. Under write-back mode, changes to 0Dh must survive a reload; a design that deferred them would lose them.

The bench issues a second commit while the first is busy. A design that dropped it would leave the second byte unsaved and would show no second busy window. The bench also writes to the read-only register and to undefined addresses and reads them back. This exposes stray storage and wrong fill bits.

// File: rtl/cfg_shadow_regs.sv
module cfg_shadow_regs #(
  parameter int         COMMIT_CYCLES = 8,
  parameter logic [4:0] FACTORY_OS    = 5'h12,
  parameter logic [9:0] PRESC_INIT    = 10'h180,
  parameter logic [9:0] DAC_INIT      = 10'h1F4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_reload,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       nv_busy,
  output logic [9:0] presc_word,
  output logic [9:0] dac_word,
  output logic [4:0] offset_sel,
  output logic [2:0] dev_addr
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [7:0] A_PRE_H = 8'h02, A_PRE_L = 8'h03, A_DAC_H = 8'h08,
                         A_DAC_L = 8'h09, A_CTL = 8'h0D, A_OFF = 8'h0E,
                         A_RANGE = 8'h37, A_STORE = 8'h3F;

  logic [9:0] pre_q, dac_q, bk_pre, bk_dac, pre_n, dac_n;
  logic [4:0] off_q, bk_off, off_n;
  logic [3:0] ctl_q, bk_ctl, ctl_n;
  logic [3:0] pend, req, mask;
  logic [CW-1:0] cnt;

  wire we      = wr_en & ~boot_reload;
  wire hit_ph  = we && addr == A_PRE_H;
  wire hit_pl  = we && addr == A_PRE_L;
  wire hit_dh  = we && addr == A_DAC_H;
  wire hit_dl  = we && addr == A_DAC_L;
  wire hit_ctl = we && addr == A_CTL;
  wire hit_off = we && addr == A_OFF;
  wire hit_st  = we && addr == A_STORE;
  wire thru    = ~ctl_q[3];

  always_comb begin
    if (boot_reload) begin
      pre_n = bk_pre; dac_n = bk_dac; off_n = bk_off; ctl_n = bk_ctl;
    end else begin
      pre_n = hit_ph ? {wdata, pre_q[1:0]} : hit_pl ? {pre_q[9:2], wdata[7:6]} : pre_q;
      dac_n = hit_dh ? {wdata, dac_q[1:0]} : hit_dl ? {dac_q[9:2], wdata[7:6]} : dac_q;
      off_n = hit_off ? wdata[4:0] : off_q;
      ctl_n = hit_ctl ? wdata[3:0] : ctl_q;
    end
  end

  assign req[0] = ((hit_ph | hit_pl) & thru) | hit_st;
  assign req[1] = ((hit_dh | hit_dl) & thru) | hit_st;
  assign req[2] = (hit_off & thru) | hit_st;
  assign req[3] = hit_ctl | hit_st;
  assign mask   = req | pend;
  wire   go     = (cnt == '0) && (mask != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRESC_INIT; dac_q <= DAC_INIT; off_q <= FACTORY_OS; ctl_q <= 4'h0;
      bk_pre <= PRESC_INIT; bk_dac <= DAC_INIT; bk_off <= FACTORY_OS; bk_ctl <= 4'h0;
      pend <= '0;
      cnt  <= '0;
    end else begin
      pre_q <= pre_n; dac_q <= dac_n; off_q <= off_n; ctl_q <= ctl_n;
      if (go) begin
        if (mask[0]) bk_pre <= pre_n;
        if (mask[1]) bk_dac <= dac_n;
        if (mask[2]) bk_off <= off_n;
        if (mask[3]) bk_ctl <= ctl_n;
        pend <= '0;
        cnt  <= CW'(COMMIT_CYCLES);
      end else begin
        pend <= boot_reload ? '0 : mask;
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (addr)
      A_PRE_H: rd_mux = pre_q[9:2];
      A_PRE_L: rd_mux = {pre_q[1:0], 6'b0};
      A_DAC_H: rd_mux = dac_q[9:2];
      A_DAC_L: rd_mux = {dac_q[1:0], 6'b0};
      A_CTL:   rd_mux = {4'hF, ctl_q};
      A_OFF:   rd_mux = {3'b111, off_q};
      A_RANGE: rd_mux = {3'b000, FACTORY_OS};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end

  assign nv_busy    = cnt != '0;
  assign presc_word = pre_q;
  assign dac_word   = dac_q;
  assign offset_sel = off_q;
  assign dev_addr   = ctl_q[2:0];
endmodule

// File: rtl/cfg_shadow_regs_chk.sv
module cfg_shadow_regs_chk #(
  parameter int         COMMIT_CYCLES = 8,
  parameter logic [4:0] FACTORY_OS    = 5'h12,
  parameter int         CW            = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boot_reload,
  input logic          rd_en,
  input logic          wr_en,
  input logic [7:0]    addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          nv_busy,
  input logic          wc,
  input logic [9:0]    bk_dac,
  input logic [3:0]    bk_ctl,
  input logic [CW-1:0] cnt
);
  p_range_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'h37 |=> rdata == {3'b000, FACTORY_OS});

  p_undef_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr >= 8'h40 |=> rdata == 8'h00);

  p_ctl_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'h0D |=> rdata[7:4] == 4'hF);

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_thru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !boot_reload && !nv_busy && !wc && addr == 8'h08 |=> bk_dac[9:2] == $past(wdata));

  p_ctl_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !boot_reload && !nv_busy && addr == 8'h0D |=> bk_ctl == $past(wdata[3:0]));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !boot_reload && !nv_busy && addr == 8'h3F |=> nv_busy && cnt == CW'(COMMIT_CYCLES));

  p_cnt_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> cnt == $past(cnt) - 1'b1);
endmodule

bind cfg_shadow_regs cfg_shadow_regs_chk #(
  .COMMIT_CYCLES(COMMIT_CYCLES), .FACTORY_OS(FACTORY_OS), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_reload(boot_reload), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .nv_busy(nv_busy), .wc(ctl_q[3]),
  .bk_dac(bk_dac), .bk_ctl(bk_ctl), .cnt(cnt)
);

// File: tb/tb_cfg_shadow_regs.sv
`timescale 1ns/1ps
module tb_cfg_shadow_regs;
  localparam int NCYC = 8;
  logic clk = 0, rst_n = 0, boot_reload = 0, rd_en = 0, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic nv_busy;
  logic [9:0] presc_word, dac_word;
  logic [4:0] offset_sel;
  logic [2:0] dev_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  cfg_shadow_regs #(.COMMIT_CYCLES(NCYC)) dut (
    .clk(clk), .rst_n(rst_n), .boot_reload(boot_reload), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .nv_busy(nv_busy), .presc_word(presc_word),
    .dac_word(dac_word), .offset_sel(offset_sel), .dev_addr(dev_addr));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; rd_en = 0; boot_reload = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (nv_busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic reload();
    boot_reload = 1; @(negedge clk); boot_reload = 0;
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk(8'h02, 8'h60, "R1 presc hi");
    rd_chk(8'h03, 8'h00, "R1 presc lo");
    rd_chk(8'h08, 8'h7D, "R1 dac hi");
    rd_chk(8'h09, 8'h00, "R1 dac lo");
    rd_chk(8'h0D, 8'hF0, "R1 ctl");
    rd_chk(8'h0E, 8'hF2, "R1 offset");
    rd_chk(8'h37, 8'h12, "R1 range");
    chk("R1 busy idle", nv_busy, 0);
  endtask

  task automatic t_fill();
    do_reset();
    wr(8'h03, 8'hFF); rd_chk(8'h03, 8'hC0, "R2 presc lo fill");
    wr(8'h09, 8'hFF); rd_chk(8'h09, 8'hC0, "R2 dac lo fill");
    wr(8'h0E, 8'hE0); rd_chk(8'h0E, 8'hE0, "R2 offset fill");
    wr(8'h0D, 8'h00); rd_chk(8'h0D, 8'hF0, "R2 ctl fill");
    wait_idle();
  endtask

  task automatic t_ro_undef();
    do_reset();
    wr(8'h37, 8'h00); rd_chk(8'h37, 8'h12, "R3 range unwritable");
    wr(8'h05, 8'hAA); rd_chk(8'h05, 8'h00, "R4 undef 05 read zero");
    wr(8'h40, 8'h55); rd_chk(8'h40, 8'h00, "R4 undef 40 read zero");
    rd_chk(8'h08, 8'h7D, "R4 dac untouched");
    rd_chk(8'h0E, 8'hF2, "R4 offset untouched");
    chk("R4 no commit from undef", nv_busy, 0);
  endtask

  task automatic t_through();
    do_reset();
    wr(8'h08, 8'hA1); wr(8'h09, 8'hC0);
    wait_idle();
    repeat (2) @(negedge clk);
    wait_idle();
    wr(8'h08, 8'h00); wr(8'h09, 8'h00);
    chk("R12 dac out before reload", dac_word, 0);
    wait_idle(); repeat (2) @(negedge clk); wait_idle();
    wr(8'h0D, 8'h08); wait_idle();
    wr(8'h08, 8'hA1); wr(8'h09, 8'hC0);
    reload();
    rd_chk(8'h08, 8'h00, "R5 last through value kept");
    chk("R12 dac out reloaded", dac_word, 0);
    do_reset();
    wr(8'h08, 8'hA1); wr(8'h09, 8'hC0);
    wait_idle(); repeat (2) @(negedge clk); wait_idle();
    wr(8'h08, 8'h11);
    wait_idle();
    reload();
    rd_chk(8'h08, 8'h11, "R5 hi through");
    rd_chk(8'h09, 8'hC0, "R5 lo through");
    chk("R12 dac_word", dac_word, 10'h047);
  endtask

  task automatic t_defer();
    do_reset();
    wr(8'h0D, 8'h08); wait_idle();
    wr(8'h0E, 8'h10);
    rd_chk(8'h0E, 8'hF0, "R6 working offset");
    chk("R6 no commit", nv_busy, 0);
    reload();
    rd_chk(8'h0E, 8'hF2, "R6 offset restored");
    chk("R12 offset_sel", offset_sel, 5'h12);
    rd_chk(8'h0D, 8'hF8, "R8 ctl kept");
  endtask

  task automatic t_store();
    do_reset();
    wr(8'h0D, 8'h08);
    wr(8'h02, 8'h12);
    wr(8'h3F, 8'h00);
    wait_idle(); repeat (2) @(negedge clk); wait_idle();
    reload();
    rd_chk(8'h02, 8'h12, "R7 store committed");
    chk("R12 presc_word", presc_word, 10'h048);
  endtask

  task automatic t_ctl();
    do_reset();
    wr(8'h0D, 8'h08); wait_idle();
    wr(8'h0D, 8'h0D); wait_idle();
    reload();
    rd_chk(8'h0D, 8'hFD, "R8 ctl write-through in wc=1");
    chk("R8 dev_addr", dev_addr, 5);
  endtask

  task automatic t_busy();
    int n = 0;
    do_reset();
    wr(8'h0E, 8'h13);
    while (nv_busy && n < 100) begin n++; @(negedge clk); end
    chk("R9 busy length", n, NCYC);
  endtask

  task automatic t_queue();
    do_reset();
    wr(8'h08, 8'h11);
    wr(8'h09, 8'h40);
    wait_idle();
    chk("R10 gap", nv_busy, 0);
    @(negedge clk);
    chk("R10 queued commit starts", nv_busy, 1);
    wait_idle();
    reload();
    rd_chk(8'h09, 8'h40, "R10 queued data saved");
    rd_chk(8'h08, 8'h11, "R10 first data saved");
  endtask

  task automatic t_hold();
    do_reset();
    rd_chk(8'h0E, 8'hF2, "R11 read");
    wr(8'h0E, 8'h1F);
    chk("R11 hold without rd_en", rdata, 8'hF2);
    rd_chk(8'h0E, 8'hFF, "R11 new read");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_ro_undef();
    t_through();
    t_defer();
    t_store();
    t_ctl();
    t_busy();
    t_queue();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule